// File: doc/BRIEF.md
# System I/O Control Register Block

This block is a register file that sits on a simple synchronous bus. It answers a fixed set of byte-wide I/O ports and one small memory-mapped window. Through these ports the firmware can request a CPU hard reset, set four system-control inhibit flags, pick the I/O map type, and read fixed equipment and board-identity bytes. The stored reset bit drives the reset request output, and the stored map-type bit drives the map select output. Both outputs come straight from register flops.

Bits inside each register are numbered from the most significant end: bit n has weight 2^(7-n). Bit 7 is therefore 0x01 and bit 0 is 0x80. Some ports are write-only. A write to one of them completes normally and changes nothing. A write to the reset port that asks for little-endian operation is not carried out. Instead it sets a sticky halt request. The 4-byte parity window always reads zero and reports a bus error on any write or on any access that is not 4 bytes wide.

Every access is acknowledged on the edge that follows the request. Read data and the error flag are valid together with the acknowledge. An I/O read returns its byte in bits 7:0, with the upper bits at zero.

Top module: `sysio_ctrl_regs`

## Requirements
- R1: Port 0x092 stores only value 0x01 (bit 7) of a written byte. It reads that stored bit back, and `cpuResetReq` follows the stored bit. No other access changes `cpuResetReq`.
- R2: A write to port 0x092 with value 0x02 (bit 6) set raises `haltReq`. The rest of that write takes effect as in R1. `haltReq` stays high until reset.
- R3: Port 0x81C stores only mask 0xF0 (bits 0 to 3) of a written byte. The other bits read back as zero.
- R4: Port 0x850 stores only value 0x01 and reads it back. `ioMapNonContig` follows the stored bit and changes on no other access.
- R5: Port 0x80C reads the parameter `EQUIP_BYTE` and port 0x852 reads the parameter `BOARD_ID`. Both parameters default to 0. Writes to these two ports change no state.
- R6: Writes to ports 0x808, 0x810, 0x812 and 0x814 complete without error and change no state. Reads of these ports return 0xFFFFFFFF. Port 0x818 reads 0.
- R7: In the window at `WIN_BASE`, a 4-byte read returns 0 with `busErr` low. Any write, or any access whose size is not 4 bytes, returns `busErr` high, and a read of this kind returns 0.
- R8: A read from any other address (I/O or memory) returns 0xFFFFFFFF with `busErr` low, and it changes no state.
- R9: `busAck` is high exactly in the cycle after each request and low otherwise. `rdData` and `busErr` are valid while `busAck` is high, and a write returns `rdData` = 0.
- R10: Synchronous reset clears the reset bit, the system-control register and `haltReq`. It sets the map-type register to 0x01, so `ioMapNonContig` is high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Request strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busMem | input | 1 | 1 for memory space, 0 for I/O space |
| busAddr | input | ADDR_W | Access address |
| busSize | input | 3 | Access size in bytes (1 to 4) |
| wrData | input | 32 | Write data; I/O ports use bits 7:0 |
| busAck | output | 1 | Access acknowledge |
| busErr | output | 1 | Invalid access, valid with busAck |
| rdData | output | 32 | Read data, valid with busAck |
| cpuResetReq | output | 1 | CPU hard-reset request |
| ioMapNonContig | output | 1 | Non-contiguous I/O map select |
| haltReq | output | 1 | Sticky unsupported-mode halt request |

## Verification
A request presented in cycle k is registered on one edge. Its acknowledge, read data and error flag are therefore due in cycle k+1. Register side effects on `cpuResetReq`, `ioMapNonContig` and `haltReq` become visible on that same edge. The bench drives each request on a falling edge and samples every result on the next falling edge, which is half a cycle after the single register stage. It then checks that `busAck` is low again in the idle cycle that follows.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  function automatic logic [7:0] msbBit(input int n);
    return 8'(1 << (7 - n));
  endfunction

  localparam logic [7:0] RST_KEEP   = msbBit(7);
  localparam logic [7:0] LE_REQ     = msbBit(6);
  localparam logic [7:0] SYSCTL_KEEP = msbBit(0) | msbBit(1) | msbBit(2) | msbBit(3);
  localparam logic [7:0] MAP_KEEP   = msbBit(7);

  localparam logic [15:0] P_RESET  = 16'h0092;
  localparam logic [15:0] P_LIGHT  = 16'h0808;
  localparam logic [15:0] P_EQUIP  = 16'h080C;
  localparam logic [15:0] P_PASS1  = 16'h0810;
  localparam logic [15:0] P_PASS2  = 16'h0812;
  localparam logic [15:0] P_CINV   = 16'h0814;
  localparam logic [15:0] P_KEY    = 16'h0818;
  localparam logic [15:0] P_SYSCTL = 16'h081C;
  localparam logic [15:0] P_MAP    = 16'h0850;
  localparam logic [15:0] P_BOARD  = 16'h0852;

  typedef enum logic [2:0] {
    RD_ONES, RD_ZERO, RD_RST, RD_SYSCTL, RD_MAP, RD_EQUIP, RD_BOARD
  } rdSel_e;

  typedef struct packed {
    logic   active;
    logic   wrRst;
    logic   wrSysCtl;
    logic   wrMap;
    logic   leFault;
    logic   accErr;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/sysio_ctrl.sv
module sysio_ctrl
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hBFFF_EFF0
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busMem,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [7:0]        wrByte,
  output strobes_t          strb
);

  localparam int WIN_LSB = 2;

  logic ioHit;
  logic winHit;

  assign ioHit  = !busMem && (busAddr[ADDR_W-1:16] == '0);
  assign winHit = busMem && (busAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_ONES;
    if (busValid) begin
      strb.active = 1'b1;
      if (winHit) begin
        strb.rdSel  = RD_ZERO;
        strb.accErr = busWrite || (busSize != 3'd4);
      end else if (ioHit) begin
        unique case (busAddr[15:0])
          P_RESET: begin
            strb.rdSel   = RD_RST;
            strb.wrRst   = busWrite;
            strb.leFault = busWrite && ((wrByte & LE_REQ) != 8'h00);
          end
          P_SYSCTL: begin
            strb.rdSel    = RD_SYSCTL;
            strb.wrSysCtl = busWrite;
          end
          P_MAP: begin
            strb.rdSel = RD_MAP;
            strb.wrMap = busWrite;
          end
          P_EQUIP: strb.rdSel = RD_EQUIP;
          P_BOARD: strb.rdSel = RD_BOARD;
          P_KEY:   strb.rdSel = RD_ZERO;
          default: strb.rdSel = RD_ONES;
        endcase
      end
      if (busWrite) strb.rdSel = RD_ZERO;
    end
  end

endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [7:0] EQUIP_BYTE = 8'h00,
  parameter logic [7:0] BOARD_ID = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic [7:0]        wrByte,
  output logic              busAck,
  output logic              busErr,
  output logic [DATA_W-1:0] rdData,
  output logic              cpuResetReq,
  output logic              ioMapNonContig,
  output logic              haltReq
);

  localparam int PAD_W = DATA_W - 8;

  logic [7:0]        rstReg;
  logic [7:0]        sysCtlReg;
  logic [7:0]        mapReg;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    unique case (strb.rdSel)
      RD_ZERO:   rdNext = '0;
      RD_RST:    rdNext = {{PAD_W{1'b0}}, rstReg};
      RD_SYSCTL: rdNext = {{PAD_W{1'b0}}, sysCtlReg};
      RD_MAP:    rdNext = {{PAD_W{1'b0}}, mapReg};
      RD_EQUIP:  rdNext = {{PAD_W{1'b0}}, EQUIP_BYTE};
      RD_BOARD:  rdNext = {{PAD_W{1'b0}}, BOARD_ID};
      default:   rdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rstReg    <= 8'h00;
      sysCtlReg <= 8'h00;
      mapReg    <= MAP_KEEP;
      haltReq   <= 1'b0;
      busAck    <= 1'b0;
      busErr    <= 1'b0;
      rdData    <= '0;
    end else begin
      if (strb.wrRst)    rstReg    <= wrByte & RST_KEEP;
      if (strb.wrSysCtl) sysCtlReg <= wrByte & SYSCTL_KEEP;
      if (strb.wrMap)    mapReg    <= wrByte & MAP_KEEP;
      if (strb.leFault)  haltReq   <= 1'b1;
      busAck <= strb.active;
      busErr <= strb.accErr;
      rdData <= strb.active ? rdNext : '0;
    end
  end

  assign cpuResetReq    = |(rstReg & RST_KEEP);
  assign ioMapNonContig = |(mapReg & MAP_KEEP);

endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hBFFF_EFF0,
  parameter logic [7:0] EQUIP_BYTE = 8'h00,
  parameter logic [7:0] BOARD_ID = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busMem,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [31:0]       wrData,
  output logic              busAck,
  output logic              busErr,
  output logic [31:0]       rdData,
  output logic              cpuResetReq,
  output logic              ioMapNonContig,
  output logic              haltReq
);

  strobes_t strb;

  sysio_ctrl #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busMem(busMem),
    .busAddr(busAddr), .busSize(busSize), .wrByte(wrData[7:0]), .strb(strb)
  );

  sysio_regs #(.DATA_W(32), .EQUIP_BYTE(EQUIP_BYTE), .BOARD_ID(BOARD_ID)) u_regs (
    .clk(clk), .rst(rst), .strb(strb), .wrByte(wrData[7:0]),
    .busAck(busAck), .busErr(busErr), .rdData(rdData),
    .cpuResetReq(cpuResetReq), .ioMapNonContig(ioMapNonContig), .haltReq(haltReq)
  );

endmodule

// File: rtl/sysio_ctrl_regs_chk.sv
module sysio_ctrl_regs_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hBFFF_EFF0
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic              busWrite,
  input logic              busMem,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busAck,
  input logic              busErr,
  input logic              cpuResetReq,
  input logic              ioMapNonContig,
  input logic              haltReq
);

  logic wrRstPort;
  logic wrMapPort;
  logic winWrite;

  assign wrRstPort = busValid && busWrite && !busMem && (busAddr == ADDR_W'(16'h0092));
  assign wrMapPort = busValid && busWrite && !busMem && (busAddr == ADDR_W'(16'h0850));
  assign winWrite  = busValid && busWrite && busMem &&
                     (busAddr[ADDR_W-1:2] == WIN_BASE[ADDR_W-1:2]);

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    busValid |=> busAck) else $error("ack missing"); // R9
  AST_NO_IDLE_ACK: assert property (@(posedge clk) disable iff (rst)
    !busValid |=> !busAck) else $error("stray ack"); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    haltReq |=> haltReq) else $error("halt dropped"); // R2
  AST_RESET_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrRstPort |=> $stable(cpuResetReq)) else $error("reset req moved"); // R1
  AST_MAP_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !wrMapPort |=> $stable(ioMapNonContig)) else $error("map sel moved"); // R4
  AST_WIN_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
    winWrite |=> busErr) else $error("window write not flagged"); // R7
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    busErr |-> busAck) else $error("error without ack"); // R9

endmodule

bind sysio_ctrl_regs sysio_ctrl_regs_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busMem(busMem),
  .busAddr(busAddr), .busAck(busAck), .busErr(busErr), .cpuResetReq(cpuResetReq),
  .ioMapNonContig(ioMapNonContig), .haltReq(haltReq)
);

// File: tb/sysio_ctrl_regs_tb.sv
module sysio_ctrl_regs_tb;

  localparam logic [31:0] WBASE = 32'hBFFF_EFF0;
  localparam logic [7:0]  EQ    = 8'hA5;
  localparam logic [7:0]  BID   = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0, busWrite = 1'b0, busMem = 1'b0;
  logic [31:0] busAddr = '0;
  logic [2:0]  busSize = 3'd1;
  logic [31:0] wrData = '0;
  logic        busAck, busErr, cpuResetReq, ioMapNonContig, haltReq;
  logic [31:0] rdData;

  int nChecks = 0;
  int nErrors = 0;
  logic [31:0] gotRd;
  logic gotAck, gotErr;

  always #5 clk = ~clk;

  sysio_ctrl_regs #(.ADDR_W(32), .WIN_BASE(WBASE), .EQUIP_BYTE(EQ), .BOARD_ID(BID)) u_dut (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busMem(busMem),
    .busAddr(busAddr), .busSize(busSize), .wrData(wrData), .busAck(busAck),
    .busErr(busErr), .rdData(rdData), .cpuResetReq(cpuResetReq),
    .ioMapNonContig(ioMapNonContig), .haltReq(haltReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic mem, input logic wr, input logic [31:0] addr,
                     input logic [2:0] sz, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busMem = mem; busAddr = addr; busSize = sz; wrData = data;
    @(negedge clk);
    gotRd = rdData; gotAck = busAck; gotErr = busErr;
    busValid = 1'b0; busWrite = 1'b0;
    chk("R9 ack", {31'b0, gotAck}, 32'd1);
  endtask

  task automatic ioRd(input logic [15:0] a, input logic [31:0] exp, input string req);
    acc(1'b0, 1'b0, {16'h0, a}, 3'd1, '0);
    chk(req, gotRd, exp);
    chk(req, {31'b0, gotErr}, 32'd0);
  endtask

  task automatic ioWr(input logic [15:0] a, input logic [7:0] d);
    acc(1'b0, 1'b1, {16'h0, a}, 3'd1, {24'h0, d});
    chk("R9 write data", gotRd, 32'd0);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nErrors++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin : main
    logic expHalt;
    doReset();
    // R10 reset state
    chk("R10 cpuResetReq", {31'b0, cpuResetReq}, 0);
    chk("R10 ioMapNonContig", {31'b0, ioMapNonContig}, 1);
    chk("R10 haltReq", {31'b0, haltReq}, 0);
    chk("R9 idle ack", {31'b0, busAck}, 0);
    ioRd(16'h0092, 32'h0, "R10 reset port");
    ioRd(16'h081C, 32'h0, "R10 sysctl");
    ioRd(16'h0850, 32'h1, "R10 map");

    // R1 / R2 sweep of the reset port
    expHalt = 1'b0;
    for (int v = 0; v < 256; v++) begin
      ioWr(16'h0092, 8'(v));
      if ((v & 2) != 0) expHalt = 1'b1;
      chk("R1 cpuResetReq", {31'b0, cpuResetReq}, 32'(v & 1));
      chk("R2 haltReq", {31'b0, haltReq}, {31'b0, expHalt});
      ioRd(16'h0092, 32'(v & 1), "R1 readback");
      @(negedge clk);
      chk("R9 idle ack", {31'b0, busAck}, 0);
    end
    ioWr(16'h0092, 8'h00);

    // R3 sweep
    for (int v = 0; v < 256; v++) begin
      ioWr(16'h081C, 8'(v));
      ioRd(16'h081C, 32'(v & 8'hF0), "R3 sysctl mask");
    end

    // R4 sweep
    for (int v = 0; v < 256; v++) begin
      ioWr(16'h0850, 8'(v));
      chk("R4 ioMapNonContig", {31'b0, ioMapNonContig}, 32'(v & 1));
      ioRd(16'h0850, 32'(v & 1), "R4 map readback");
    end

    // known state: sysctl=0x50, map=1, reset bit=1
    ioWr(16'h081C, 8'h5A);
    ioWr(16'h0850, 8'h01);
    ioWr(16'h0092, 8'h01);

    // R5 fixed bytes, writes ignored
    for (int v = 0; v < 256; v += 17) begin
      ioWr(16'h080C, 8'(v));
      ioWr(16'h0852, 8'(v));
      ioRd(16'h080C, {24'h0, EQ}, "R5 equipment");
      ioRd(16'h0852, {24'h0, BID}, "R5 board id");
    end
    ioRd(16'h081C, 32'h50, "R5 no side effect");

    // R6 write-only ports and keylock
    for (int v = 0; v < 256; v += 51) begin
      ioWr(16'h0808, 8'(v)); chk("R6 no err", {31'b0, gotErr}, 0);
      ioWr(16'h0810, 8'(v)); chk("R6 no err", {31'b0, gotErr}, 0);
      ioWr(16'h0812, 8'(v)); chk("R6 no err", {31'b0, gotErr}, 0);
      ioWr(16'h0814, 8'(v)); chk("R6 no err", {31'b0, gotErr}, 0);
    end
    ioWr(16'h0818, 8'hFF);
    ioRd(16'h0092, 32'h1, "R6 reset bit kept");
    ioRd(16'h081C, 32'h50, "R6 sysctl kept");
    ioRd(16'h0850, 32'h1, "R6 map kept");
    chk("R6 cpuResetReq kept", {31'b0, cpuResetReq}, 1);
    ioRd(16'h0808, 32'hFFFF_FFFF, "R6 wo read");
    ioRd(16'h0810, 32'hFFFF_FFFF, "R6 wo read");
    ioRd(16'h0812, 32'hFFFF_FFFF, "R6 wo read");
    ioRd(16'h0814, 32'hFFFF_FFFF, "R6 wo read");
    ioRd(16'h0818, 32'h0, "R6 keylock");

    // R7 parity window: all sizes, both directions, all four offsets
    for (int off = 0; off < 4; off++) begin
      for (int sz = 1; sz <= 4; sz++) begin
        for (int wr = 0; wr < 2; wr++) begin
          acc(1'b1, 1'(wr), WBASE + 32'(off), 3'(sz), 32'hDEAD_BEEF);
          chk("R7 window data", gotRd, 32'h0);
          chk("R7 window err", {31'b0, gotErr}, 32'((wr == 1 || sz != 4) ? 1 : 0));
        end
      end
    end

    // R8 undecoded addresses
    ioRd(16'h0093, 32'hFFFF_FFFF, "R8 undecoded io");
    ioRd(16'h0800, 32'hFFFF_FFFF, "R8 undecoded io");
    ioRd(16'h0851, 32'hFFFF_FFFF, "R8 undecoded io");
    acc(1'b0, 1'b0, 32'h0001_0092, 3'd1, '0);
    chk("R8 high io addr", gotRd, 32'hFFFF_FFFF);
    acc(1'b1, 1'b0, WBASE + 32'd4, 3'd4, '0);
    chk("R8 undecoded mem", gotRd, 32'hFFFF_FFFF);
    chk("R8 undecoded mem err", {31'b0, gotErr}, 0);
    acc(1'b1, 1'b0, 32'h0000_0092, 3'd1, '0);
    chk("R8 mem alias", gotRd, 32'hFFFF_FFFF);
    acc(1'b0, 1'b1, 32'h0000_0093, 3'd1, 32'hFF);
    ioRd(16'h081C, 32'h50, "R8 no side effect");
    chk("R8 map kept", {31'b0, ioMapNonContig}, 1);

    // R10 reset clears halt and restores map
    ioWr(16'h0850, 8'h00);
    chk("R4 map low", {31'b0, ioMapNonContig}, 0);
    chk("R2 halt before reset", {31'b0, haltReq}, 1);
    doReset();
    chk("R10 halt cleared", {31'b0, haltReq}, 0);
    chk("R10 map restored", {31'b0, ioMapNonContig}, 1);
    chk("R10 reset req cleared", {31'b0, cpuResetReq}, 0);
    ioRd(16'h081C, 32'h0, "R10 sysctl cleared");
    // R2 write of 0x02 alone: halt, reset bit stays low
    ioWr(16'h0092, 8'h02);
    chk("R2 halt set", {31'b0, haltReq}, 1);
    chk("R2 reset bit low", {31'b0, cpuResetReq}, 0);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule